// File: doc/BRIEF.md
# Contrast-Scoring Lens Focus Sweeper

This block finds the sharpest lens position for a camera whose lens is moved by a voice-coil driver. It watches the raw pixel stream from the sensor. The stream carries a frame sync, a line sync and a per-pixel valid strobe. For each frame the block builds a sharpness score. The score adds up the absolute differences between pixels of the same colour phase, which sit two columns apart on the same line. Only pixels inside a measurement window count. The window is either the whole frame or a fixed central rectangle.

A single start pulse launches one search. The block commands the lens to positions 0, STEP, 2·STEP and so on, up to the highest multiple of STEP that does not exceed the limit. After each command is acknowledged, the block lets one complete frame pass while the lens settles. It scores the next complete frame. It then moves the lens to the position with the highest score, with ties going to the lower position.

Every lens command leaves the block as a write request for an external I2C master. The request carries the 7-bit device address, a register index and the lens code. An overlay flag marks the outline of the central window on the live video while the area select input is high.

Top module: `focus_sweep`

## Requirements
- R1: A start pulse while idle begins a search, and busy is high from the next cycle until the search completes. A start pulse while busy is ignored: the command sequence and the result are unchanged.
- R2: Each lens command is a request with device address 0x18, register index LENS_REG and the lens code as data. The request stays high with stable data until the cycle in which the acknowledge is high. Only one request is outstanding at a time.
- R3: Within a search, the lens codes are commanded in the order 0, STEP, 2·STEP, … up to the last multiple of STEP that is not above LIMIT. One further command then carries the chosen best code.
- R4: After each acknowledged step command, the first complete frame that starts afterwards is not scored. The complete frame after that one is the frame scored for that position.
- R5: The score of a frame is the sum, over every valid pixel at column c of a line, of |pixel(c) − pixel(c−2)|. A pixel contributes only when both columns c and c−2 lie inside the window on that row. The sum is kept in SUM_W bits.
- R6: The area select value is captured at start. A value of 0 scores the whole frame. A value of 1 scores only columns WIN_X0..WIN_X1 and rows WIN_Y0..WIN_Y1. Changing area select during a search does not alter that search.
- R7: The chosen code belongs to the position with the strictly largest score. With equal scores, the lower code wins. If every score is zero, the chosen code is 0.
- R8: Done is high for exactly one cycle, right after the acknowledge of the final command. At that point busy is low, and the lens code output holds the chosen code until the next search.
- R9: The outline output is high only when area select is 1 and a valid pixel lies on the border of the central window. The border is the first or last window column within the window rows, or the first or last window row within the window columns.
- R10: A rising frame sync sets the pixel position to column 0, row 0. A rising line sync sets the column to 0. Each valid pixel advances the column, and the row advances when the column wraps after COLS pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | One-cycle request to run a focus search |
| area_sel | input | 1 | 0: whole-frame window, 1: central window |
| vsync | input | 1 | Frame sync; its rising edge starts a frame |
| hsync | input | 1 | Line sync; its rising edge starts a line |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Raw pixel value |
| wr_ack | input | 1 | Acknowledge from the I2C master |
| wr_req | output | 1 | Write request pending |
| wr_dev | output | 7 | Device address of the write |
| wr_reg | output | 8 | Register index of the write |
| wr_data | output | LENS_W | Lens code to write |
| lens_code | output | LENS_W | Most recently commanded lens code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the search has finished |
| outline | output | 1 | Window-border flag for the video overlay |

## Verification
The bench drives a lens model whose image contrast depends on the acknowledged lens code. It also fills the settle frame that follows each command with very high contrast. A design that scored the settle frame, or the partly finished frame running at acknowledge time, would then pick the wrong position.

The sweep covers several kinds of scoring input:
- a clear interior peak;
- a two-way tie, which exposes a non-strict compare by choosing the later code;
- an all-zero response;
- a peak at the last step, which catches an off-by-one in the step limit;
- strong contrast outside the central window, so that a wrong window or a window read live instead of captured at start changes the answer.

A second start pulse arrives in the middle of one search. A design that restarted on it would emit extra commands. The outline is compared pixel by pixel against the window border, which catches an off-by-one in the column or row count.

// File: rtl/focus_pkg.sv
package focus_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STEP_WR,
    S_WAIT_SOF_A,
    S_SETTLE,
    S_WAIT_SOF_B,
    S_SCORE,
    S_FINAL_WR
  } sweep_state_e;

  // absolute difference of two pixel values
  function automatic int unsigned pix_absdiff(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // point inside an inclusive rectangle
  function automatic logic in_rect(int unsigned c, int unsigned r,
                                   int unsigned x0, int unsigned x1,
                                   int unsigned y0, int unsigned y1);
    return (c >= x0) && (c <= x1) && (r >= y0) && (r <= y1);
  endfunction

  // point on the edge of an inclusive rectangle
  function automatic logic on_border(int unsigned c, int unsigned r,
                                     int unsigned x0, int unsigned x1,
                                     int unsigned y0, int unsigned y1);
    return in_rect(c, r, x0, x1, y0, y1) &&
           ((c == x0) || (c == x1) || (r == y0) || (r == y1));
  endfunction

endpackage

// File: rtl/focus_raster.sv
module focus_raster #(
  parameter int COLS = 1280,
  parameter int ROWS = 720,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             hsync,
  input  logic             pix_valid,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             sof,
  output logic             last_pix
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic vs_q, hs_q;
  logic line_start;

  assign sof        = vsync & ~vs_q;
  assign line_start = hsync & ~hs_q;
  assign last_pix   = pix_valid && (col == COL_LAST) && (row == ROW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
      hs_q <= 1'b0;
      col  <= '0;
      row  <= '0;
    end else begin
      vs_q <= vsync;
      hs_q <= hsync;
      if (sof) begin
        col <= '0;
        row <= '0;
      end else if (line_start) begin
        col <= '0;
      end else if (pix_valid) begin
        if (col == COL_LAST) begin
          col <= '0;
          row <= (row == ROW_LAST) ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/focus_hf_accum.sv
module focus_hf_accum import focus_pkg::*; #(
  parameter int PIX_W = 10,
  parameter int COL_W = 11,
  parameter int ROW_W = 10,
  parameter int SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             sof,
  input  logic             last_pix,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] win_x0,
  input  logic [COL_W-1:0] win_x1,
  input  logic [ROW_W-1:0] win_y0,
  input  logic [ROW_W-1:0] win_y1,
  output logic [SUM_W-1:0] frame_sum,
  output logic             sum_valid
);
  logic [PIX_W-1:0] hist1, hist2;
  logic [SUM_W-1:0] acc;
  logic             pair_ok;
  logic [SUM_W-1:0] term;
  logic [SUM_W-1:0] acc_next;

  // both the current pixel and the one two columns back lie in the window
  assign pair_ok = pix_valid &&
                   in_rect(32'(col), 32'(row), 32'(win_x0), 32'(win_x1),
                           32'(win_y0), 32'(win_y1)) &&
                   (32'(col) >= 32'(win_x0) + 32'd2);
  assign term     = pair_ok ? SUM_W'(pix_absdiff(32'(pix_data), 32'(hist2))) : '0;
  assign acc_next = acc + term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist1     <= '0;
      hist2     <= '0;
      acc       <= '0;
      frame_sum <= '0;
      sum_valid <= 1'b0;
    end else begin
      sum_valid <= 1'b0;
      if (pix_valid) begin
        hist1 <= pix_data;
        hist2 <= hist1;
      end
      if (sof) begin
        acc <= '0;
      end else if (pix_valid) begin
        acc <= acc_next;
      end
      if (last_pix) begin
        frame_sum <= acc_next;
        sum_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/focus_search.sv
module focus_search import focus_pkg::*; #(
  parameter int LENS_W = 10,
  parameter int SUM_W  = 32,
  parameter int STEP   = 32,
  parameter int LIMIT  = 1020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              area_sel,
  input  logic              wr_ack,
  input  logic              sof,
  input  logic              last_pix,
  input  logic [SUM_W-1:0]  frame_sum,
  input  logic              sum_valid,
  output logic              area_q,
  output logic              wr_req,
  output logic [LENS_W-1:0] code_q,
  output logic              busy,
  output logic              done,
  output logic              score_take
);
  localparam int unsigned LAST_POS = (LIMIT / STEP) * STEP;
  localparam logic [LENS_W-1:0] STEP_C = LENS_W'(STEP);

  sweep_state_e      state;
  logic [LENS_W-1:0] pos;
  logic [LENS_W-1:0] best_pos;
  logic [SUM_W-1:0]  best_sum;
  logic              better;
  logic [LENS_W-1:0] pick_pos;
  logic              at_end;

  assign better     = frame_sum > best_sum;   // strict: ties keep earlier
  assign pick_pos   = better ? pos : best_pos;
  assign at_end     = (32'(pos) >= LAST_POS);
  assign busy       = (state != S_IDLE);
  assign score_take = (state == S_SCORE) && sum_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      area_q   <= 1'b0;
      wr_req   <= 1'b0;
      code_q   <= '0;
      pos      <= '0;
      best_pos <= '0;
      best_sum <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          area_q   <= area_sel;
          pos      <= '0;
          best_pos <= '0;
          best_sum <= '0;
          code_q   <= '0;
          wr_req   <= 1'b1;
          state    <= S_STEP_WR;
        end
        S_STEP_WR: if (wr_ack) begin
          wr_req <= 1'b0;
          state  <= S_WAIT_SOF_A;
        end
        S_WAIT_SOF_A: if (sof) state <= S_SETTLE;
        S_SETTLE:     if (last_pix) state <= S_WAIT_SOF_B;
        S_WAIT_SOF_B: if (sof) state <= S_SCORE;
        S_SCORE: if (sum_valid) begin
          if (better) best_sum <= frame_sum;
          best_pos <= pick_pos;
          wr_req   <= 1'b1;
          if (at_end) begin
            code_q <= pick_pos;
            state  <= S_FINAL_WR;
          end else begin
            pos    <= pos + STEP_C;
            code_q <= pos + STEP_C;
            state  <= S_STEP_WR;
          end
        end
        S_FINAL_WR: if (wr_ack) begin
          wr_req <= 1'b0;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/focus_sweep.sv
module focus_sweep import focus_pkg::*; #(
  parameter int COLS     = 1280,
  parameter int ROWS     = 720,
  parameter int PIX_W    = 10,
  parameter int LENS_W   = 10,
  parameter int SUM_W    = 32,
  parameter int STEP     = 32,
  parameter int LIMIT    = 1020,
  parameter int WIN_X0   = 480,
  parameter int WIN_X1   = 799,
  parameter int WIN_Y0   = 270,
  parameter int WIN_Y1   = 449,
  parameter logic [6:0] DEV_ADDR = 7'h18,
  parameter logic [7:0] LENS_REG = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              area_sel,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [6:0]        wr_dev,
  output logic [7:0]        wr_reg,
  output logic [LENS_W-1:0] wr_data,
  output logic [LENS_W-1:0] lens_code,
  output logic              busy,
  output logic              done,
  output logic              outline
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [COL_W-1:0] CX0 = COL_W'(WIN_X0);
  localparam logic [COL_W-1:0] CX1 = COL_W'(WIN_X1);
  localparam logic [ROW_W-1:0] CY0 = ROW_W'(WIN_Y0);
  localparam logic [ROW_W-1:0] CY1 = ROW_W'(WIN_Y1);
  localparam logic [COL_W-1:0] FX1 = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] FY1 = ROW_W'(ROWS - 1);

  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic              sof, last_pix;
  logic [SUM_W-1:0]  frame_sum;
  logic              sum_valid;
  logic              area_q;
  logic              score_take;
  logic [LENS_W-1:0] code_q;
  logic [COL_W-1:0]  win_x0, win_x1;
  logic [ROW_W-1:0]  win_y0, win_y1;

  assign win_x0 = area_q ? CX0 : '0;
  assign win_x1 = area_q ? CX1 : FX1;
  assign win_y0 = area_q ? CY0 : '0;
  assign win_y1 = area_q ? CY1 : FY1;

  focus_raster #(.COLS(COLS), .ROWS(ROWS)) u_raster (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
    .pix_valid(pix_valid), .col(col), .row(row), .sof(sof), .last_pix(last_pix)
  );

  focus_hf_accum #(.PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .sof(sof), .last_pix(last_pix), .col(col), .row(row),
    .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
    .frame_sum(frame_sum), .sum_valid(sum_valid)
  );

  focus_search #(.LENS_W(LENS_W), .SUM_W(SUM_W), .STEP(STEP), .LIMIT(LIMIT)) u_search (
    .clk(clk), .rst_n(rst_n), .start(start), .area_sel(area_sel), .wr_ack(wr_ack),
    .sof(sof), .last_pix(last_pix), .frame_sum(frame_sum), .sum_valid(sum_valid),
    .area_q(area_q), .wr_req(wr_req), .code_q(code_q), .busy(busy), .done(done),
    .score_take(score_take)
  );

  assign wr_dev    = DEV_ADDR;
  assign wr_reg    = LENS_REG;
  assign wr_data   = code_q;
  assign lens_code = code_q;
  assign outline   = pix_valid && area_sel &&
                     on_border(32'(col), 32'(row), WIN_X0, WIN_X1, WIN_Y0, WIN_Y1);
endmodule

// File: rtl/focus_sweep_chk.sv
module focus_sweep_chk #(
  parameter int LENS_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              area_sel,
  input logic              pix_valid,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [LENS_W-1:0] wr_data,
  input logic              busy,
  input logic              done,
  input logic              outline,
  input logic              score_take
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data)));

  p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);

  p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wr_req));

  p_outline_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outline |-> (pix_valid && area_sel));

  p_score_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    score_take |-> (busy && !wr_req));
endmodule

bind focus_sweep focus_sweep_chk #(.LENS_W(LENS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .area_sel(area_sel),
  .pix_valid(pix_valid), .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
  .busy(busy), .done(done), .outline(outline), .score_take(score_take)
);

// File: tb/focus_sweep_tb.sv
module focus_sweep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 16, ROWS = 8, PIX_W = 10, LENS_W = 10;
  localparam int STEP = 256, LIMIT = 1020, NPOS = 4;
  localparam int X0 = 4, X1 = 11, Y0 = 2, Y1 = 5;
  localparam logic [7:0] LREG = 8'h05;

  logic clk = 0, rst_n = 0;
  logic start = 0, area_sel = 0, vsync = 0, hsync = 0, pix_valid = 0, wr_ack = 0;
  logic [PIX_W-1:0] pix_data = '0;
  logic wr_req, busy, done, outline;
  logic [6:0] wr_dev;
  logic [7:0] wr_reg;
  logic [LENS_W-1:0] wr_data, lens_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  focus_sweep #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W), .LENS_W(LENS_W), .SUM_W(32),
    .STEP(STEP), .LIMIT(LIMIT), .WIN_X0(X0), .WIN_X1(X1), .WIN_Y0(Y0), .WIN_Y1(Y1),
    .DEV_ADDR(7'h18), .LENS_REG(LREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .area_sel(area_sel), .vsync(vsync),
    .hsync(hsync), .pix_valid(pix_valid), .pix_data(pix_data), .wr_ack(wr_ack),
    .wr_req(wr_req), .wr_dev(wr_dev), .wr_reg(wr_reg), .wr_data(wr_data),
    .lens_code(lens_code), .busy(busy), .done(done), .outline(outline));

  int nchk = 0, nerr = 0;
  int amp_in[NPOS], amp_out[NPOS];
  int lens_now = 0;
  bit settle_pending = 0;
  int wcount = 0;
  int wvals[16];
  int done_cnt = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit inwin(int c, int r);
    return c >= X0 && c <= X1 && r >= Y0 && r <= Y1;
  endfunction

  function automatic int pv(int c, int r, int ain, int aout);
    int a = inwin(c, r) ? ain : aout;
    return ((c / 2) % 2 == 0) ? 100 + a : 100;
  endfunction

  function automatic int exp_sum(int ain, int aout, bit area);
    int s = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 2; c < COLS; c++) begin
        bit ok = area ? (r >= Y0 && r <= Y1 && c - 2 >= X0 && c <= X1) : 1'b1;
        int d = pv(c, r, ain, aout) - pv(c - 2, r, ain, aout);
        if (ok) s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  function automatic int exp_best(bit area);
    int bs = exp_sum(amp_in[0], amp_out[0], area), bp = 0;
    for (int i = 1; i < NPOS; i++) begin
      int s = exp_sum(amp_in[i], amp_out[i], area);
      if (s > bs) begin bs = s; bp = i * STEP; end
    end
    return bp;
  endfunction

  // acknowledge model of the I2C master plus lens motion
  initial begin
    int wait_n = 0;
    forever begin
      @(negedge clk);
      if (wr_ack) wr_ack = 0;
      else if (wr_req) begin
        if (wait_n == 2) begin
          wr_ack = 1; wait_n = 0;
          check(wr_dev == 7'h18 && wr_reg == LREG, "R2 dev/reg", int'(wr_dev), 'h18);
          if (wcount < 16) wvals[wcount] = int'(wr_data);
          wcount++;
          lens_now = int'(wr_data);
          settle_pending = 1;
        end else wait_n++;
      end
    end
  end

  always @(negedge clk) if (rst_n && done) done_cnt++;

  // frame generator with per-pixel outline checks (R9, R10)
  task automatic run_frame();
    bit settle = settle_pending;
    int idx = lens_now / STEP;
    int ain, aout, k = 0;
    bit ol_ok = 1;
    settle_pending = 0;
    ain  = settle ? 900 : amp_in[idx];
    aout = settle ? 900 : amp_out[idx];
    vsync = 1; repeat (2) @(negedge clk); vsync = 0; @(negedge clk);
    for (int r = 0; r < ROWS; r++) begin
      hsync = 1; @(negedge clk); hsync = 0; @(negedge clk);
      for (int c = 0; c < COLS; c++) begin
        if (k % 5 == 4) begin
          pix_valid = 0; #1;
          if (outline) ol_ok = 0;
          @(negedge clk);
        end
        k++;
        pix_valid = 1; pix_data = PIX_W'(pv(c, r, ain, aout)); #1;
        if (outline !== (area_sel && (inwin(c, r) &&
            (c == X0 || c == X1 || r == Y0 || r == Y1)))) ol_ok = 0;
        @(negedge clk);
      end
      pix_valid = 0; repeat (2) @(negedge clk);
    end
    check(ol_ok, "R9/R10 outline per pixel", ol_ok, 1);
  endtask

  initial begin
    wait (rst_n);
    forever run_frame();
  end

  task automatic search(bit area, bit disturb, string tag);
    int expb = exp_best(area);
    wcount = 0; done_cnt = 0;
    @(negedge clk); area_sel = area; start = 1;
    @(negedge clk); start = 0;
    check(busy == 1, {"R1 busy after start ", tag}, busy, 1);
    if (disturb) begin
      repeat (400) @(negedge clk);
      area_sel = ~area; start = 1;
      @(negedge clk); start = 0;
      check(busy == 1, {"R1 still busy ", tag}, busy, 1);
    end
    while (!done) @(negedge clk);
    check(busy == 0, {"R8 busy low at done ", tag}, busy, 0);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, {"R8 single done ", tag}, done_cnt, 1);
    check(int'(lens_code) == expb, {"R7 best code ", tag}, int'(lens_code), expb);
    check(wcount == NPOS + 1, {"R3 write count ", tag}, wcount, NPOS + 1);
    for (int i = 0; i < NPOS; i++)
      check(wvals[i] == i * STEP, {"R3 step order ", tag}, wvals[i], i * STEP);
    check(wvals[NPOS] == expb, {"R3 final write ", tag}, wvals[NPOS], expb);
    area_sel = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R1 watchdog actual=busy expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !wr_req && lens_code == 0 && !outline,
          "R1 reset state", int'(busy), 0);
    rst_n = 1;
    // R5 R6: interior peak, contrast outside window at last step
    amp_in  = '{10, 40, 25, 5};  amp_out = '{0, 0, 0, 300};
    search(1, 0, "central");
    search(0, 0, "whole");
    // R6 R1: area change and second start mid-search are ignored
    search(1, 1, "disturb");
    // R7 tie keeps lower code
    amp_in  = '{20, 50, 50, 10}; amp_out = '{0, 0, 0, 0};
    search(1, 0, "tie");
    // R7 all zero gives code 0
    amp_in  = '{0, 0, 0, 0};     amp_out = '{0, 0, 0, 0};
    search(0, 0, "zero");
    // R3 peak at last step, R4 settle frame ignored
    amp_in  = '{1, 2, 3, 60};    amp_out = '{5, 5, 5, 5};
    search(1, 0, "last");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule